// File: doc/BRIEF.md
# DMA Bus Handover Controller with Write Snooping

This block sits on the processor side of a shared system bus. It decides when a DMA device may take the bus and when the processor gets it back. A device raises a request. The controller lets the processor's bus cycle in flight complete, then drives a grant. Once the device confirms the grant, the processor bus unit is stalled and the controller watches the bus.

While the device owns the bus, every DMA write address is compared against a small direct-mapped tag store that mirrors the processor's cached lines. On a hit the entry is handled according to a mode input. In invalidate mode its valid bit is cleared. In update mode the written data replaces the entry's data and the entry stays valid.

When the device signals release, the controller answers with a one-cycle release acknowledge and drops the grant in that same cycle. It then lets the processor resume. The processor loads entries through a fill port and reads them through a combinational lookup port. Fills are accepted only while the processor owns the bus.

Top module: `dma_bus_handover`

## Requirements
- R1: While reset is active and after it is released, grant_o, rel_ack_o and cpu_stall_o are 0 and every tag entry reads as a miss (lk_hit_o = 0).
- R2: After dev_req_i is sampled high, grant_o stays 0 for as long as cpu_busy_i is 1. It rises one cycle after the first edge that samples dev_req_i = 1 with cpu_busy_i = 0 in the waiting phase.
- R3: With grant_o = 1, an edge that samples dev_gack_i = 1 (and dev_req_i = 1) makes cpu_stall_o = 1 from the next cycle, with grant_o still 1.
- R4: If dev_req_i is sampled low while waiting for the cycle to finish or while granted but not yet acknowledged, the controller returns to idle: grant_o goes to 0 and cpu_stall_o is never raised.
- R5: An edge that samples dev_rel_i = 1 during snooping gives exactly one cycle of rel_ack_o = 1. In that cycle grant_o = 0 and cpu_stall_o = 1. In the following cycle rel_ack_o = 0 and cpu_stall_o = 0.
- R6: A request still held high in the idle cycle after the release acknowledge starts a new handover, with grant_o rising again once cpu_busy_i is 0.
- R7: In snooping, a write strobe (snp_wr_i = 1) with snp_mode_i = 0 (invalidate) that hits a valid entry clears it, so a later lookup of that address misses.
- R8: In snooping, a write strobe with snp_mode_i = 1 (update) that hits stores snp_data_i into the entry, which stays valid.
- R9: A snooped write whose index matches but whose tag differs leaves that entry's valid bit, tag and data unchanged.
- R10: snp_wr_i has no effect on the tag store while the controller is not snooping.
- R11: fill_i writes valid = 1, the tag and fill_data_i into the indexed entry when cpu_stall_o = 0, and is ignored while cpu_stall_o = 1.
- R12: Addresses split into index = addr[2:0] and tag = addr[15:3]. lk_hit_o is 1 when the indexed entry is valid and its tag equals lk_addr_i[15:3]. lk_data_o is the indexed entry's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_req_i | input | 1 | Device bus request |
| dev_gack_i | input | 1 | Device acknowledges the grant |
| dev_rel_i | input | 1 | Device releases the bus |
| cpu_busy_i | input | 1 | Processor bus cycle still in progress |
| grant_o | output | 1 | Bus granted to the device |
| rel_ack_o | output | 1 | One-cycle acknowledge of the release |
| cpu_stall_o | output | 1 | Holds the processor bus unit |
| snp_wr_i | input | 1 | DMA write strobe seen on the bus |
| snp_mode_i | input | 1 | 0 = invalidate on hit, 1 = update on hit |
| snp_addr_i | input | 16 | DMA write address |
| snp_data_i | input | 8 | DMA write data |
| fill_i | input | 1 | Processor fill of a tag entry |
| fill_addr_i | input | 16 | Fill address |
| fill_data_i | input | 8 | Fill data |
| lk_addr_i | input | 16 | Lookup address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_data_o | output | 8 | Data of the indexed entry |

## Verification
The hardest case to reach is a snooped write that lands on a valid entry while the bus is genuinely owned by the device. Getting there takes the whole handshake: request with a busy cycle, grant, acknowledge. A miss on the same index must also be shown to leave the entry intact. The stimulus fills several entries first and walks the full handover with a stretched busy phase. It then replays a table of hits and same-index misses in both modes, checking each through the lookup port. A fill during the stall and a write strobe outside snooping show that both are ignored.

// File: rtl/dma_ho_pkg.sv
package dma_ho_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FINISH  = 3'd1,
    ST_GRANTED = 3'd2,
    ST_SNOOP   = 3'd3,
    ST_RELACK  = 3'd4
  } ho_state_e;

  localparam logic SNP_MODE_INVAL  = 1'b0;
  localparam logic SNP_MODE_UPDATE = 1'b1;

endpackage

// File: rtl/dma_ho_rst_sync.sv
module dma_ho_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dma_ho_fsm.sv
module dma_ho_fsm
  import dma_ho_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic gack_i,
  input  logic rel_i,
  input  logic busy_i,
  output logic grant_o,
  output logic rel_ack_o,
  output logic stall_o,
  output logic snoop_en_o
);

  ho_state_e state_q;
  ho_state_e state_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) state_d = ST_FINISH;
      end
      ST_FINISH: begin
        if (!req_i)       state_d = ST_IDLE;
        else if (!busy_i) state_d = ST_GRANTED;
      end
      ST_GRANTED: begin
        if (!req_i)      state_d = ST_IDLE;
        else if (gack_i) state_d = ST_SNOOP;
      end
      ST_SNOOP: begin
        if (rel_i) state_d = ST_RELACK;
      end
      ST_RELACK: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Moore output decode
  always_comb begin
    grant_o    = 1'b0;
    rel_ack_o  = 1'b0;
    stall_o    = 1'b0;
    snoop_en_o = 1'b0;
    unique case (state_q)
      ST_GRANTED: grant_o = 1'b1;
      ST_SNOOP: begin
        grant_o    = 1'b1;
        stall_o    = 1'b1;
        snoop_en_o = 1'b1;
      end
      ST_RELACK: begin
        rel_ack_o = 1'b1;
        stall_o   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dma_snoop_tags.sv
module dma_snoop_tags
  import dma_ho_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoop_en_i,
  input  logic              snp_wr_i,
  input  logic              snp_mode_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [DATA_W-1:0] snp_data_i,
  input  logic              fill_en_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [TAG_W-1:0]   tag_d  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [DATA_W-1:0]  data_d [ENTRIES];

  logic [IDX_W-1:0] snp_idx, fill_idx, lk_idx;
  logic [TAG_W-1:0] snp_tag, fill_tag, lk_tag;

  assign snp_idx  = snp_addr_i[IDX_W-1:0];
  assign snp_tag  = snp_addr_i[ADDR_W-1:IDX_W];
  assign fill_idx = fill_addr_i[IDX_W-1:0];
  assign fill_tag = fill_addr_i[ADDR_W-1:IDX_W];
  assign lk_idx   = lk_addr_i[IDX_W-1:0];
  assign lk_tag   = lk_addr_i[ADDR_W-1:IDX_W];

  logic [ENTRIES-1:0] snp_hit;
  logic [ENTRIES-1:0] fill_sel;

  // per-entry snoop comparators and fill decode
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign snp_hit[g]  = snoop_en_i && snp_wr_i && (snp_idx == IDX_W'(g))
                         && valid_q[g] && (tag_q[g] == snp_tag);
    assign fill_sel[g] = fill_en_i && (fill_idx == IDX_W'(g));
  end

  // next-state of the store
  always_comb begin
    valid_d = valid_q;
    for (int i = 0; i < ENTRIES; i++) begin
      tag_d[i]  = tag_q[i];
      data_d[i] = data_q[i];
      if (snp_hit[i]) begin
        if (snp_mode_i == SNP_MODE_UPDATE) begin
          data_d[i] = snp_data_i;
        end else begin
          valid_d[i] = 1'b0;
        end
      end else if (fill_sel[i]) begin
        valid_d[i] = 1'b1;
        tag_d[i]   = fill_tag;
        data_d[i]  = fill_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // tag and data storage carry no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (snp_hit[i] || fill_sel[i]) begin
        tag_q[i]  <= tag_d[i];
        data_q[i] <= data_d[i];
      end
    end
  end

  assign lk_hit_o  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data_o = data_q[lk_idx];

endmodule

// File: rtl/dma_bus_handover.sv
module dma_bus_handover #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_req_i,
  input  logic              dev_gack_i,
  input  logic              dev_rel_i,
  input  logic              cpu_busy_i,
  output logic              grant_o,
  output logic              rel_ack_o,
  output logic              cpu_stall_o,
  input  logic              snp_wr_i,
  input  logic              snp_mode_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [DATA_W-1:0] snp_data_i,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o
);

  logic rst_sync_n;
  logic snoop_en;
  logic fill_en;

  dma_ho_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_ho_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_i      (dev_req_i),
    .gack_i     (dev_gack_i),
    .rel_i      (dev_rel_i),
    .busy_i     (cpu_busy_i),
    .grant_o    (grant_o),
    .rel_ack_o  (rel_ack_o),
    .stall_o    (cpu_stall_o),
    .snoop_en_o (snoop_en)
  );

  // the processor may only fill while it owns the bus
  assign fill_en = fill_i && !cpu_stall_o;

  dma_snoop_tags #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) i_tags (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .snoop_en_i  (snoop_en),
    .snp_wr_i    (snp_wr_i),
    .snp_mode_i  (snp_mode_i),
    .snp_addr_i  (snp_addr_i),
    .snp_data_i  (snp_data_i),
    .fill_en_i   (fill_en),
    .fill_addr_i (fill_addr_i),
    .fill_data_i (fill_data_i),
    .lk_addr_i   (lk_addr_i),
    .lk_hit_o    (lk_hit_o),
    .lk_data_o   (lk_data_o)
  );

endmodule

// File: rtl/dma_bus_handover_chk.sv
module dma_bus_handover_chk (
  input logic clk,
  input logic rst_n,
  input logic dev_req_i,
  input logic dev_gack_i,
  input logic dev_rel_i,
  input logic cpu_busy_i,
  input logic grant_o,
  input logic rel_ack_o,
  input logic cpu_stall_o
);

  p_grant_after_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> $past(dev_req_i && !cpu_busy_i))
    else $error("grant rose without a free bus cycle");

  p_stall_after_gack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall_o) |-> $past(grant_o && dev_gack_i))
    else $error("stall rose without an acknowledged grant");

  p_drop_no_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && !cpu_stall_o && !dev_req_i) |=> (!grant_o && !cpu_stall_o))
    else $error("dropped request did not return to idle");

  p_relack_no_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ack_o |-> (!grant_o && cpu_stall_o))
    else $error("release acknowledge with grant or without stall");

  p_relack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ack_o |=> (!rel_ack_o && !cpu_stall_o))
    else $error("release acknowledge longer than one cycle");

  p_relack_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_ack_o) |-> $past(dev_rel_i && cpu_stall_o))
    else $error("release acknowledge without a release");

endmodule

bind dma_bus_handover dma_bus_handover_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dev_req_i   (dev_req_i),
  .dev_gack_i  (dev_gack_i),
  .dev_rel_i   (dev_rel_i),
  .cpu_busy_i  (cpu_busy_i),
  .grant_o     (grant_o),
  .rel_ack_o   (rel_ack_o),
  .cpu_stall_o (cpu_stall_o)
);

// File: tb/test_dma_bus_handover.sv
module test_dma_bus_handover;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dev_req_i, dev_gack_i, dev_rel_i, cpu_busy_i;
  logic        grant_o, rel_ack_o, cpu_stall_o;
  logic        snp_wr_i, snp_mode_i;
  logic [15:0] snp_addr_i;
  logic [7:0]  snp_data_i;
  logic        fill_i;
  logic [15:0] fill_addr_i;
  logic [7:0]  fill_data_i;
  logic [15:0] lk_addr_i;
  logic        lk_hit_o;
  logic [7:0]  lk_data_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dma_bus_handover i_dma_bus_handover (.*);

  typedef struct packed {
    logic        mode;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [15:0] lk;
    logic        hit;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'h1230, 8'h00, 16'h1230, 1'b0, 8'h00},  // R7 invalidate hit
    '{1'b1, 16'h4561, 8'hA5, 16'h4561, 1'b1, 8'hA5},  // R8 update hit
    '{1'b1, 16'h9992, 8'h77, 16'h7892, 1'b1, 8'h33},  // R9 tag miss, update
    '{1'b0, 16'h0003, 8'h00, 16'hABC3, 1'b1, 8'h44},  // R9 tag miss, invalidate
    '{1'b0, 16'hABC3, 8'h00, 16'hABC3, 1'b0, 8'h00},  // R7 invalidate hit
    '{1'b1, 16'h7892, 8'h5A, 16'h7892, 1'b1, 8'h5A}   // R8 update hit
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fill(input logic [15:0] a, input logic [7:0] d);
    fill_i = 1'b1; fill_addr_i = a; fill_data_i = d;
    nclk(1);
    fill_i = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    dev_req_i = 0; dev_gack_i = 0; dev_rel_i = 0; cpu_busy_i = 0;
    snp_wr_i = 0; snp_mode_i = 0; snp_addr_i = '0; snp_data_i = '0;
    fill_i = 0; fill_addr_i = '0; fill_data_i = '0; lk_addr_i = 16'h1230;
    nclk(3);
    chk("R1 grant in reset", grant_o, 0);
    chk("R1 stall in reset", cpu_stall_o, 0);
    chk("R1 relack in reset", rel_ack_o, 0);
    chk("R1 entry invalid", lk_hit_o, 0);
    rst_n = 1'b1;
    nclk(3);
    chk("R1 grant after reset", grant_o, 0);

    // processor fills four entries (R11, R12)
    fill(16'h1230, 8'h11);
    fill(16'h4561, 8'h22);
    fill(16'h7892, 8'h33);
    fill(16'hABC3, 8'h44);
    lk_addr_i = 16'h4561; #1;
    chk("R11 fill hit", lk_hit_o, 1);
    chk("R11 fill data", lk_data_o, 8'h22);
    lk_addr_i = 16'h4569; #1;
    chk("R12 different tag same index misses", lk_hit_o, 0);

    // R10: write strobe outside snooping
    snp_wr_i = 1; snp_mode_i = 0; snp_addr_i = 16'h1230;
    nclk(1);
    snp_wr_i = 0; lk_addr_i = 16'h1230; #1;
    chk("R10 idle write ignored", lk_hit_o, 1);

    // R2: request while processor cycle busy
    dev_req_i = 1; cpu_busy_i = 1;
    nclk(4);
    chk("R2 no grant while busy", grant_o, 0);
    cpu_busy_i = 0;
    nclk(1);
    chk("R2 grant after busy ends", grant_o, 1);
    chk("R2 no stall before ack", cpu_stall_o, 0);
    // R10: strobe while granted but not yet acknowledged
    snp_wr_i = 1; snp_mode_i = 0; snp_addr_i = 16'h1230;
    dev_gack_i = 1;
    nclk(1);
    snp_wr_i = 0; dev_gack_i = 0; #1;
    chk("R10 granted-state write ignored", lk_hit_o, 1);
    chk("R3 stall after ack", cpu_stall_o, 1);
    chk("R3 grant held", grant_o, 1);

    // R11: fill ignored while stalled
    fill(16'h0004, 8'h55);
    lk_addr_i = 16'h0004; #1;
    chk("R11 stalled fill ignored", lk_hit_o, 0);

    // snoop vector table
    foreach (VECS[k]) begin
      snp_wr_i = 1; snp_mode_i = VECS[k].mode;
      snp_addr_i = VECS[k].addr; snp_data_i = VECS[k].data;
      lk_addr_i = VECS[k].lk;
      nclk(1);
      snp_wr_i = 0; #1;
      chk($sformatf("R7/R8/R9 vector %0d hit", k), lk_hit_o, VECS[k].hit);
      if (VECS[k].hit) chk($sformatf("R8/R9 vector %0d data", k), lk_data_o, VECS[k].exp);
    end

    // R5 release, R6 pending request restarts
    dev_rel_i = 1;
    nclk(1);
    chk("R5 relack", rel_ack_o, 1);
    chk("R5 grant dropped", grant_o, 0);
    chk("R5 stall during relack", cpu_stall_o, 1);
    dev_rel_i = 0;
    nclk(1);
    chk("R5 relack one cycle", rel_ack_o, 0);
    chk("R5 resume", cpu_stall_o, 0);
    chk("R6 idle cycle no grant", grant_o, 0);
    nclk(2);
    chk("R6 restart grant", grant_o, 1);

    // R4: drop in granted state
    dev_req_i = 0;
    nclk(1);
    chk("R4 grant dropped", grant_o, 0);
    chk("R4 no stall", cpu_stall_o, 0);

    // R4: drop while waiting on busy cycle
    dev_req_i = 1; cpu_busy_i = 1;
    nclk(2);
    dev_req_i = 0; cpu_busy_i = 0;
    nclk(3);
    chk("R4 drop while finishing", grant_o, 0);
    chk("R4 drop while finishing stall", cpu_stall_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule